// File: doc/BRIEF.md
# Reference-Synchronized Time Base Counter

This block keeps the 16-bit global time of a time-triggered message controller. The count goes up by one on every tick of a prescaled timer clock. The count restarts at zero when a reference frame has been fully received in the designated last mailbox. That restart is seen as a rising edge on that mailbox's message-ready flag, and it starts a new time window. A software clear strobe restarts the count in the same way.

Freeze mode can be enabled. In that mode the count stops at all-ones instead of wrapping. Stopping sets a sticky overflow flag, and reading the status word clears that flag. A maskable interrupt follows the flag. Frame events copy the running count into a global timestamp register. While time-triggered mode is active, the per-mailbox timestamp view reads as zero.

Top module: `refsync_timebase`

## Requirements
- R1: After reset, count_o, ovf_o, irq_o, stamp_o and mbox_stamp_o are all zero.
- R2: On each clock edge with tick_i high and no clear, the count rises by exactly one. With tick_i low, the count holds.
- R3: A rising edge on ref_rdy_i clears the count to zero at that clock edge. If ref_rdy_i stays high afterwards, the count is not cleared again.
- R4: sw_clr_i clears the count to zero. It wins over a tick in the same cycle.
- R5: With freeze_en_i high, a tick while the count is 0xFFFF keeps the count at 0xFFFF and sets ovf_o.
- R6: A frozen count stays at 0xFFFF until a clear (R3 or R4). This holds even if ticks keep arriving or freeze_en_i drops.
- R7: With freeze_en_i low, a tick at 0xFFFF wraps the count to 0x0000 and leaves ovf_o at zero.
- R8: status_rd_i clears ovf_o at the next edge. If a freeze event happens in the same cycle, the set wins and ovf_o ends up high.
- R9: irq_o is high exactly when ovf_o is high and ovf_irq_en_i is high.
- R10: frame_evt_i copies the count held before the edge into stamp_o. mbox_stamp_o shows the same value when tt_mode_i is low and reads zero when tt_mode_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled timer tick enable |
| ref_rdy_i | input | 1 | Message-ready flag of the last mailbox |
| sw_clr_i | input | 1 | Software counter clear strobe |
| freeze_en_i | input | 1 | Saturate at all-ones instead of wrapping |
| status_rd_i | input | 1 | Status word read strobe; clears the overflow flag |
| ovf_irq_en_i | input | 1 | Overflow interrupt mask bit |
| frame_evt_i | input | 1 | Frame event; captures the count |
| tt_mode_i | input | 1 | Time-triggered mode; blanks the per-mailbox timestamp |
| count_o | output | 16 | Current time base value |
| ovf_o | output | 1 | Sticky overflow (frozen) flag |
| irq_o | output | 1 | Overflow interrupt |
| stamp_o | output | 16 | Global timestamp capture |
| mbox_stamp_o | output | 16 | Per-mailbox timestamp view |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the freeze event and the status read that clears the flag. The bench runs the count up to 0xFFFF, then drives status_rd_i high in the very cycle the next tick would roll the count over. The check passes only if ovf_o is high afterwards. A lone read in a later cycle must then clear the flag.

The second pair is a clear and an increment. The bench drives sw_clr_i and tick_i together and expects zero, not one.

// File: rtl/refsync_pkg.sv
package refsync_pkg;
  localparam int unsigned TB_W = 16;

  typedef struct packed {
    logic clr;
    logic tick;
    logic freeze_en;
  } cnt_ctrl_t;
endpackage

// File: rtl/refsync_edge.sv
module refsync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/refsync_counter.sv
module refsync_counter
  import refsync_pkg::*;
#(
  parameter int unsigned W = TB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_ctrl_t    ctrl_i,
  output logic [W-1:0] cnt_o,
  output logic         freeze_evt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         frozen_q;
  logic         at_max;

  assign at_max       = (cnt_q == CNT_MAX);
  // first tick that would roll over while saturation is on
  assign freeze_evt_o = ~ctrl_i.clr & ctrl_i.tick & ctrl_i.freeze_en & at_max & ~frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
    end else if (ctrl_i.clr) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
    end else if (freeze_evt_o) begin
      frozen_q <= 1'b1;
    end else if (ctrl_i.tick && !frozen_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.clr |=> (cnt_q == '0));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.tick && !ctrl_i.clr && !frozen_q && !(ctrl_i.freeze_en && at_max))
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !ctrl_i.clr) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/refsync_ovf.sv
module refsync_ovf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic irq_en_i,
  output logic ovf_o,
  output logic irq_o
);
  logic ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_q <= 1'b0;
    else if (set_i) ovf_q <= 1'b1; // a new event beats a concurrent read
    else if (rd_i)  ovf_q <= 1'b0;
  end

  assign ovf_o = ovf_q;
  assign irq_o = ovf_q & irq_en_i;

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ovf_q);
  a_r8_rd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !set_i) |=> !ovf_q);
endmodule

// File: rtl/refsync_capture.sv
module refsync_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         tt_mode_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] stamp_o,
  output logic [W-1:0] mbox_o
);
  logic [W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stamp_q <= '0;
    else if (evt_i) stamp_q <= cnt_i;
  end

  assign stamp_o = stamp_q;
  assign mbox_o  = tt_mode_i ? '0 : stamp_q;

  a_r10_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (stamp_q == $past(cnt_i)));
endmodule

// File: rtl/refsync_timebase.sv
module refsync_timebase
  import refsync_pkg::*;
#(
  parameter int unsigned W = TB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ref_rdy_i,
  input  logic         sw_clr_i,
  input  logic         freeze_en_i,
  input  logic         status_rd_i,
  input  logic         ovf_irq_en_i,
  input  logic         frame_evt_i,
  input  logic         tt_mode_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o,
  output logic         irq_o,
  output logic [W-1:0] stamp_o,
  output logic [W-1:0] mbox_stamp_o
);
  logic      ref_rise;
  logic      freeze_evt;
  cnt_ctrl_t ctrl;

  refsync_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ref_rdy_i),
    .rise_o (ref_rise)
  );

  assign ctrl.clr       = ref_rise | sw_clr_i;
  assign ctrl.tick      = tick_i;
  assign ctrl.freeze_en = freeze_en_i;

  refsync_counter #(.W(W)) i_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl),
    .cnt_o        (count_o),
    .freeze_evt_o (freeze_evt)
  );

  refsync_ovf i_ovf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (freeze_evt),
    .rd_i     (status_rd_i),
    .irq_en_i (ovf_irq_en_i),
    .ovf_o    (ovf_o),
    .irq_o    (irq_o)
  );

  refsync_capture #(.W(W)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (frame_evt_i),
    .tt_mode_i (tt_mode_i),
    .cnt_i     (count_o),
    .stamp_o   (stamp_o),
    .mbox_o    (mbox_stamp_o)
  );

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_en_i && !ovf_o && !status_rd_i) |=> !ovf_o);
endmodule

// File: tb/test_refsync_timebase.sv
module test_refsync_timebase;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 0, ref_rdy_i = 0, sw_clr_i = 0, freeze_en_i = 0;
  logic        status_rd_i = 0, ovf_irq_en_i = 0, frame_evt_i = 0, tt_mode_i = 0;
  logic [15:0] count_o, stamp_o, mbox_stamp_o;
  logic        ovf_o, irq_o;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  refsync_timebase i_refsync_timebase (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ref_rdy_i(ref_rdy_i),
    .sw_clr_i(sw_clr_i), .freeze_en_i(freeze_en_i), .status_rd_i(status_rd_i),
    .ovf_irq_en_i(ovf_irq_en_i), .frame_evt_i(frame_evt_i), .tt_mode_i(tt_mode_i),
    .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o), .stamp_o(stamp_o),
    .mbox_stamp_o(mbox_stamp_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clear_cnt();
    sw_clr_i = 1; tick_i = 0; step(); sw_clr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 stamp", stamp_o, 0);
    chk("R1 mbox", mbox_stamp_o, 0);
  endtask

  task automatic t_count();
    clear_cnt();
    tick_i = 1; step(7);
    chk("R2 seven ticks", count_o, 7);
    tick_i = 0; step(3);
    chk("R2 hold without tick", count_o, 7);
    tick_i = 1; step();
    tick_i = 0; step();
    tick_i = 1; step();
    chk("R2 gapped ticks", count_o, 9);
    tick_i = 0;
  endtask

  task automatic t_swclr();
    tick_i = 1; step(4);
    sw_clr_i = 1; step(); sw_clr_i = 0;
    chk("R4 clear beats tick", count_o, 0);
    step(2);
    chk("R4 resume after clear", count_o, 2);
    tick_i = 0;
  endtask

  task automatic t_capture();
    clear_cnt();
    tick_i = 1; step(5);
    frame_evt_i = 1; step(); frame_evt_i = 0;
    chk("R10 stamp", stamp_o, 5);
    chk("R10 mbox normal", mbox_stamp_o, 5);
    tt_mode_i = 1; step();
    chk("R10 stamp in tt mode", stamp_o, 5);
    chk("R10 mbox blank in tt mode", mbox_stamp_o, 0);
    tt_mode_i = 0; tick_i = 0;
  endtask

  task automatic t_freeze();
    clear_cnt();
    freeze_en_i = 1; tick_i = 1;
    step(65535);
    chk("R5 at max", count_o, 16'hFFFF);
    chk("R5 no ovf yet", ovf_o, 0);
    status_rd_i = 1; step(); status_rd_i = 0;
    chk("R5 saturated", count_o, 16'hFFFF);
    chk("R8 set wins over read", ovf_o, 1);
    ovf_irq_en_i = 0; #1;
    chk("R9 masked", irq_o, 0);
    ovf_irq_en_i = 1; #1;
    chk("R9 unmasked", irq_o, 1);
    freeze_en_i = 0; step(5);
    chk("R6 stays frozen", count_o, 16'hFFFF);
    chk("R6 ovf sticky", ovf_o, 1);
    tick_i = 0;
    status_rd_i = 1; step(); status_rd_i = 0;
    chk("R8 read clears", ovf_o, 0);
    chk("R9 irq drops", irq_o, 0);
    ref_rdy_i = 1; step();
    chk("R3 ref edge unfreezes", count_o, 0);
    tick_i = 1; step(3);
    chk("R3 held level no reclear", count_o, 3);
    ref_rdy_i = 0; tick_i = 0; ovf_irq_en_i = 0;
  endtask

  task automatic t_wrap();
    clear_cnt();
    freeze_en_i = 0; tick_i = 1;
    step(65535);
    chk("R7 at max", count_o, 16'hFFFF);
    step();
    chk("R7 wrapped", count_o, 0);
    chk("R7 no ovf", ovf_o, 0);
    tick_i = 0;
  endtask

  initial begin
    #20;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_swclr();
    t_capture();
    t_freeze();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule